// File: doc/BRIEF.md
# Dual-Port Column Sampling Chain

This block is the digital front end of a display column driver. A single start pulse enters a one-hot shift register. On each shift-clock edge that register selects one pair of adjacent pixel columns. Two pixel ports, A and B, each carry an 18-bit red/green/blue value. Both ports are registered and then written into the selected pair of a sampling memory, so a full line takes half as many clocks as there are columns.

The scan can run upward or downward, and the two start-pulse pins trade the input and cascade-output roles to match. The last selected pair raises a one-clock cascade pulse that starts the next driver in a chain. A rising edge on the line-latch input copies the whole sampling memory into a hold memory, which drives the column outputs. While those outputs stay on display, the next line loads into the sampling memory.

Top module: `disp_sample_chain`

## Requirements
- R1: Synchronous active-high reset clears the sampling and hold memories (`col_out` all zero), drives `sp_lo_out` and `sp_hi_out` low and clears both output enables, so that both pins are inputs.
- R2: With `scan_rev`=0, the start pulse is taken from `sp_lo_in`. The port values present at the clock edge that samples the start go to step 0. Step k is written on edge k+1 after the start: port A goes to column 2k and port B to column 2k+1. Column c occupies `col_out[c*18 +: 18]`, with red in bits 17:12, green in 11:6 and blue in 5:0.
- R3: With `scan_rev`=1, the start pulse is taken from `sp_hi_in`, and step k writes port A to column NCOL-1-2k and port B to column NCOL-2-2k.
- R4: After the edge that writes the last step, the cascade pulse is high for exactly one clock. It appears on `sp_hi_out` in upward scan and on `sp_lo_out` in downward scan. The other out pin stays low.
- R5: From the edge after `scan_rev` is sampled, `sp_hi_oe`=1 and `sp_lo_oe`=0 in upward scan, and the reverse in downward scan. The two enables are never high together.
- R6: The hold memory is loaded only on the first clock edge at which `line_latch` is seen high after being low. Keeping the strobe high does not copy again.
- R7: A copy and a write on the same edge: the hold memory receives the sampling memory as it stood before that edge's write.
- R8: A pulse on the pin that currently plays the cascade-output role does not start a line.
- R9: While no line is in progress, port data does not change the sampling memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_rev | input | 1 | 0 = upward column scan, 1 = downward |
| sp_lo_in | input | 1 | Low-end start pin, input side |
| sp_lo_out | output | 1 | Low-end start pin, cascade output side |
| sp_lo_oe | output | 1 | Low-end start pin output enable |
| sp_hi_in | input | 1 | High-end start pin, input side |
| sp_hi_out | output | 1 | High-end start pin, cascade output side |
| sp_hi_oe | output | 1 | High-end start pin output enable |
| pix_a | input | 18 | Port A pixel {red, green, blue} |
| pix_b | input | 18 | Port B pixel {red, green, blue} |
| line_latch | input | 1 | Line-latch strobe, acts on its rising edge |
| col_out | output | NCOL*18 | Hold memory, column c at bits c*18 +: 18 |

## Verification
In downward scan, the bench checks that port A lands in the higher column of each pair. A design with swapped lanes would mirror every pixel pair. The bench raises the strobe in the middle of a line. A design that copied after the write would show the newest pair in the held line too early. The bench holds the strobe high across a whole line, where a level-triggered copy would let the displayed line follow the sampling. It also pulses the output-role pin while idle, where a design with wrong pin muxing would start a spurious line and emit a cascade pulse.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    localparam int CH_W  = 6;
    localparam int PIX_W = 3 * CH_W;

    typedef struct packed {
        logic [CH_W-1:0] red;
        logic [CH_W-1:0] grn;
        logic [CH_W-1:0] blu;
    } pix_t;

    typedef enum logic {
        SCAN_FWD = 1'b0,
        SCAN_REV = 1'b1
    } scan_e;

    // Column that receives port A for physical pair p; port B takes the other one.
    function automatic int lane_a_col(scan_e dir, int p);
        return (dir == SCAN_REV) ? (2 * p + 1) : (2 * p);
    endfunction

endpackage

// File: rtl/dsc_token_chain.sv
module dsc_token_chain
    import dsc_pkg::*;
#(
    parameter int NPAIR = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  scan_e            dir,
    input  logic             start,
    output logic [NPAIR-1:0] tok
);

    localparam logic [NPAIR-1:0] LOW_END  = {{(NPAIR-1){1'b0}}, 1'b1};
    localparam logic [NPAIR-1:0] HIGH_END = {1'b1, {(NPAIR-1){1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            tok <= '0;
        end else if (start) begin
            tok <= (dir == SCAN_REV) ? HIGH_END : LOW_END;
        end else if (dir == SCAN_REV) begin
            tok <= tok >> 1;
        end else begin
            tok <= tok << 1;
        end
    end

    p_token_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tok));

    p_token_clear_r1: assert property (@(posedge clk)
        rst |=> (tok == '0));

endmodule

// File: rtl/dsc_data_latch.sv
module dsc_data_latch
    import dsc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  pix_t in_a,
    input  pix_t in_b,
    output pix_t lat_a,
    output pix_t lat_b
);

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_a <= '0;
            lat_b <= '0;
        end else begin
            lat_a <= in_a;
            lat_b <= in_b;
        end
    end

endmodule

// File: rtl/dsc_line_store.sv
module dsc_line_store
    import dsc_pkg::*;
#(
    parameter int NCOL = 128
) (
    input  logic                clk,
    input  logic                rst,
    input  scan_e               dir,
    input  logic [NCOL/2-1:0]   tok,
    input  pix_t                lat_a,
    input  pix_t                lat_b,
    input  logic                strobe,
    output pix_t [NCOL-1:0]     hold_q
);

    localparam int NPAIR = NCOL / 2;

    pix_t [NCOL-1:0] samp_q;
    logic            strobe_q;
    logic            copy_now;

    assign copy_now = strobe && !strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q <= '0;
        end else begin
            for (int p = 0; p < NPAIR; p++) begin
                if (tok[p]) begin
                    samp_q[lane_a_col(dir, p)]     <= lat_a;
                    samp_q[lane_a_col(dir, p) ^ 1] <= lat_b;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            hold_q   <= '0;
        end else begin
            strobe_q <= strobe;
            if (copy_now) begin
                hold_q <= samp_q;
            end
        end
    end

    p_hold_steady_r6: assert property (@(posedge clk) disable iff (rst)
        !(strobe && !strobe_q) |=> $stable(hold_q));

    p_idle_no_write_r9: assert property (@(posedge clk) disable iff (rst)
        (tok == '0) |=> $stable(samp_q));

endmodule

// File: rtl/disp_sample_chain.sv
module disp_sample_chain
    import dsc_pkg::*;
#(
    parameter int NCOL = 128   // even, at least 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    scan_rev,
    input  logic                    sp_lo_in,
    output logic                    sp_lo_out,
    output logic                    sp_lo_oe,
    input  logic                    sp_hi_in,
    output logic                    sp_hi_out,
    output logic                    sp_hi_oe,
    input  logic [PIX_W-1:0]        pix_a,
    input  logic [PIX_W-1:0]        pix_b,
    input  logic                    line_latch,
    output logic [NCOL*PIX_W-1:0]   col_out
);

    localparam int NPAIR = NCOL / 2;

    scan_e             dir;
    logic              start;
    logic [NPAIR-1:0]  tok;
    pix_t              lat_a;
    pix_t              lat_b;
    pix_t [NCOL-1:0]   hold;
    logic              casc_q;
    logic              oe_lo_q;
    logic              oe_hi_q;

    assign dir   = scan_e'(scan_rev);
    assign start = (dir == SCAN_REV) ? sp_hi_in : sp_lo_in;

    dsc_token_chain #(.NPAIR(NPAIR)) u_tok (
        .clk   (clk),
        .rst   (rst),
        .dir   (dir),
        .start (start),
        .tok   (tok)
    );

    dsc_data_latch u_lat (
        .clk   (clk),
        .rst   (rst),
        .in_a  (pix_t'(pix_a)),
        .in_b  (pix_t'(pix_b)),
        .lat_a (lat_a),
        .lat_b (lat_b)
    );

    dsc_line_store #(.NCOL(NCOL)) u_store (
        .clk    (clk),
        .rst    (rst),
        .dir    (dir),
        .tok    (tok),
        .lat_a  (lat_a),
        .lat_b  (lat_b),
        .strobe (line_latch),
        .hold_q (hold)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            casc_q  <= 1'b0;
            oe_lo_q <= 1'b0;
            oe_hi_q <= 1'b0;
        end else begin
            casc_q  <= (dir == SCAN_REV) ? tok[0] : tok[NPAIR-1];
            oe_lo_q <= (dir == SCAN_REV);
            oe_hi_q <= (dir == SCAN_FWD);
        end
    end

    assign sp_lo_out = casc_q && oe_lo_q;
    assign sp_hi_out = casc_q && oe_hi_q;
    assign sp_lo_oe  = oe_lo_q;
    assign sp_hi_oe  = oe_hi_q;
    assign col_out   = hold;

    p_oe_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
        !(sp_lo_oe && sp_hi_oe));

    p_casc_single_r4: assert property (@(posedge clk) disable iff (rst)
        casc_q |=> !casc_q);

    p_reset_pins_r1: assert property (@(posedge clk)
        rst |=> (!sp_lo_oe && !sp_hi_oe && !sp_lo_out && !sp_hi_out));

endmodule

// File: tb/disp_sample_chain_bench.sv
module disp_sample_chain_bench;

    localparam int NCOL  = 128;
    localparam int NPAIR = NCOL / 2;
    localparam int PW    = 18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scan_rev = 1'b0;
    logic sp_lo_in = 1'b0;
    logic sp_hi_in = 1'b0;
    logic [PW-1:0] pix_a = '0;
    logic [PW-1:0] pix_b = '0;
    logic line_latch = 1'b0;
    logic sp_lo_out, sp_lo_oe, sp_hi_out, sp_hi_oe;
    logic [NCOL*PW-1:0] col_out;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [PW-1:0] m_samp [NCOL];
    logic [PW-1:0] m_hold [NCOL];
    logic [PW-1:0] m_lat_a, m_lat_b;
    int   m_step;
    logic m_strq, m_casc, m_oelo, m_oehi;

    always #2 clk = ~clk;

    disp_sample_chain #(.NCOL(NCOL)) u_disp_sample_chain (
        .clk(clk), .rst(rst), .scan_rev(scan_rev),
        .sp_lo_in(sp_lo_in), .sp_lo_out(sp_lo_out), .sp_lo_oe(sp_lo_oe),
        .sp_hi_in(sp_hi_in), .sp_hi_out(sp_hi_out), .sp_hi_oe(sp_hi_oe),
        .pix_a(pix_a), .pix_b(pix_b), .line_latch(line_latch), .col_out(col_out)
    );

    function automatic int col_of_a(logic rev, int step);
        return rev ? (NCOL - 1 - 2 * step) : (2 * step);
    endfunction

    function automatic logic [NCOL*PW-1:0] flat_hold();
        logic [NCOL*PW-1:0] v;
        for (int c = 0; c < NCOL; c++) v[c*PW +: PW] = m_hold[c];
        return v;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NCOL; c++) begin
            m_samp[c] = '0;
            m_hold[c] = '0;
        end
        m_lat_a = '0; m_lat_b = '0; m_step = -1;
        m_strq = 0; m_casc = 0; m_oelo = 0; m_oehi = 0;
    endtask

    task automatic check_pins();
        logic elo, ehi;
        elo = m_casc && m_oelo;
        ehi = m_casc && m_oehi;
        checks++;
        if (sp_lo_out !== elo || sp_hi_out !== ehi) begin
            errors++;
            $display("FAIL R4 cascade lo/hi got %b%b expected %b%b at %0t",
                     sp_lo_out, sp_hi_out, elo, ehi, $time);
        end
        checks++;
        if (sp_lo_oe !== m_oelo || sp_hi_oe !== m_oehi) begin
            errors++;
            $display("FAIL R5 enables lo/hi got %b%b expected %b%b at %0t",
                     sp_lo_oe, sp_hi_oe, m_oelo, m_oehi, $time);
        end
    endtask

    task automatic check_hold(string tag);
        logic [NCOL*PW-1:0] exp_v;
        exp_v = flat_hold();
        checks++;
        if (col_out !== exp_v) begin
            errors++;
            for (int c = 0; c < NCOL; c++) begin
                if (col_out[c*PW +: PW] !== exp_v[c*PW +: PW]) begin
                    $display("FAIL %s column %0d got %h expected %h",
                             tag, c, col_out[c*PW +: PW], exp_v[c*PW +: PW]);
                    break;
                end
            end
        end
    endtask

    // advance one clock, updating the model with the inputs now applied
    task automatic tick();
        logic wrote_last;
        int   ca;
        wrote_last = 0;
        if (line_latch && !m_strq)
            for (int c = 0; c < NCOL; c++) m_hold[c] = m_samp[c];
        if (m_step >= 0) begin
            ca = col_of_a(scan_rev, m_step);
            m_samp[ca]     = m_lat_a;
            m_samp[ca ^ 1] = m_lat_b;
            if (m_step == NPAIR - 1) begin
                wrote_last = 1;
                m_step = -1;
            end else begin
                m_step++;
            end
        end
        if (scan_rev ? sp_hi_in : sp_lo_in) m_step = 0;
        m_casc  = wrote_last;
        m_lat_a = pix_a;
        m_lat_b = pix_b;
        m_strq  = line_latch;
        m_oelo  = scan_rev;
        m_oehi  = !scan_rev;
        @(posedge clk);
        #1;
        check_pins();
    endtask

    task automatic rand_ports();
        pix_a = PW'($urandom);
        pix_b = PW'($urandom);
    endtask

    // one full line; strobe_at >= 0 raises line_latch at that step
    task automatic run_line(int strobe_at);
        for (int k = 0; k < NPAIR; k++) begin
            rand_ports();
            if (scan_rev) sp_hi_in = (k == 0); else sp_lo_in = (k == 0);
            if (k == strobe_at) line_latch = 1'b1;
            tick();
        end
        sp_lo_in = 0; sp_hi_in = 0;
        rand_ports();
        tick();
        tick();
    endtask

    task automatic strobe_pulse(string tag);
        line_latch = 1'b1; tick();
        line_latch = 1'b0; tick();
        check_hold(tag);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired got running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R1: reset state
        check_hold("R1");
        check_pins();

        // R2: upward line, then copy
        scan_rev = 0; tick();
        run_line(-1);
        strobe_pulse("R2");

        // R6: strobe held high across a whole line, no second copy
        line_latch = 1'b1; tick();
        check_hold("R6");
        run_line(-1);
        check_hold("R6");
        line_latch = 1'b0; tick();
        check_hold("R6");

        // R3: downward line
        scan_rev = 1; tick();
        run_line(-1);
        strobe_pulse("R3");

        // R8: pulse the output-role pin while idle (low pin in downward scan)
        sp_lo_in = 1; rand_ports(); tick(); tick();
        sp_lo_in = 0;
        for (int i = 0; i < NPAIR + 4; i++) begin rand_ports(); tick(); end
        strobe_pulse("R8");
        scan_rev = 0; tick();
        sp_hi_in = 1; tick(); sp_hi_in = 0;
        for (int i = 0; i < NPAIR + 4; i++) begin rand_ports(); tick(); end
        strobe_pulse("R8");

        // R7: copy in the middle of a line
        run_line(NPAIR / 2);
        check_hold("R7");
        line_latch = 0; tick();
        strobe_pulse("R7");

        // R9: idle port activity does not reach the memory
        for (int i = 0; i < 20; i++) begin rand_ports(); tick(); end
        strobe_pulse("R9");

        // R4/R5 plus random mix of direction and strobe timing
        for (int n = 0; n < 12; n++) begin
            scan_rev = 1'($urandom);
            tick();
            run_line(($urandom % 3 == 0) ? int'($urandom % NPAIR) : -1);
            line_latch = 0; tick();
            strobe_pulse(scan_rev ? "R3" : "R2");
        end

        // R1: reset in the middle of a line
        scan_rev = 0; sp_lo_in = 1; tick(); sp_lo_in = 0;
        repeat (5) begin rand_ports(); tick(); end
        rst = 1; @(posedge clk); #1; rst = 0;
        model_reset();
        check_hold("R1");
        check_pins();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule